// File: doc/BRIEF.md
# Stored-Pixel Unpacker with Colour Palette

This block sits in a display pipeline between the memory fetch stage and the panel timing stage. Each input beat carries one stored pixel word. The block widens that word into a 24-bit colour and an 8-bit alpha value. The stored layout is chosen through a format register and can be one of the following:

- 16-bit 5-6-5 colour
- 16-bit 5-5-5 colour with one alpha bit
- packed 24-bit colour
- 32-bit colour with an unused top byte
- 32-bit colour with an 8-bit alpha byte
- 8-bit palette index

Alpha is only passed through on a side output. No blending is done.

Software writes a 5-bit format index. Bits 4:1 of the index form the layout code. Bit 0 states that the stored word holds blue in the high field and red in the low field. A separate panel-side swap bit is XORed with that order bit, and the result decides whether red and blue are exchanged at the output. Indexed pixels are looked up in a palette of 24-bit entries. A palette entry is loaded in two writes: the colour goes to a data register, then a command word names the entry. Both streams use valid/ready handshakes. Every pixel spends exactly one register stage in the block, so indexed and direct pixels stay in order.

Top module: `pix_unpack`

## Requirements
- R1: Layout code 0 (5-6-5) takes red from bits 15:11, green from 10:5 and blue from 4:0. Each narrow channel is widened by appending its own top bits, so that 0x8410 gives 0x848284 and 0xFFFF gives 0xFFFFFF. Alpha is 0xFF.
- R2: Layout code 1 (1-5-5-5) takes red from bits 14:10, green from 9:5 and blue from 4:0, each widened as in R1. Alpha is 0xFF when bit 15 is 1 and 0x00 when it is 0.
- R3: Layout codes 2 (packed 24-bit) and 3 (32-bit without alpha) take red from bits 23:16, green from 15:8 and blue from 7:0. They ignore bits 31:24 and give alpha 0xFF.
- R4: Layout code 4 takes the colour fields as in R3 and passes bits 31:24 to the alpha output.
- R5: Red and blue are exchanged at the output exactly when the format order bit (index bit 0) differs from the panel swap bit. This holds for every layout, including indexed.
- R6: Layout code 5 looks up the entry addressed by pixel bits 7:0 and gives alpha 0xFF. A palette entry is written by a write to register 1 (colour in bits 23:0), followed by a write to register 2 with bit 15 set and the entry number in bits 7:0. A register-2 write with bit 15 clear changes no entry.
- R7: A palette write in the same cycle as the acceptance of an indexed pixel for that same entry returns the entry's old colour to that pixel.
- R8: A pixel accepted at a clock edge appears on the output at that edge with out_valid high. Pixels leave in acceptance order, whatever their layouts.
- R9: While out_valid is high and out_ready is low, the output colour and alpha hold steady and in_ready is low. Otherwise in_ready is high.
- R10: After reset, out_valid is low, in_ready is high and the format register selects layout code 0 with no swap. Register 0 holds the format index in bits 4:0 and the panel swap bit in bit 8.
- R11: Layout codes 6 to 15 give black with alpha 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 format, 1 palette colour, 2 palette command |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pix | input | 32 | Stored pixel word |
| out_valid | output | 1 | Output colour valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_rgb | output | 24 | Output colour, red 23:16, green 15:8, blue 7:0 |
| out_alpha | output | 8 | Output alpha |

## Verification
A wrong captured swap flag or layout code appears on the very next output beat as exchanged red and blue bytes or misplaced fields. A wrong palette entry appears only when that entry is next read, so the bench reads each written entry back and checks the same-cycle write case separately. A lost or duplicated pipeline valid appears as a scoreboard mismatch on the following handshake. A stall that leaks shows within one cycle as a changing output while out_ready is low.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

   typedef enum logic [3:0] {
      LAY_565   = 4'd0,
      LAY_1555  = 4'd1,
      LAY_PK24  = 4'd2,
      LAY_UP32  = 4'd3,
      LAY_A32   = 4'd4,
      LAY_INDEX = 4'd5
   } layout_e;

   localparam logic [1:0] REG_FORMAT = 2'd0;
   localparam logic [1:0] REG_PDATA  = 2'd1;
   localparam logic [1:0] REG_PCMD   = 2'd2;

   localparam int CMD_BIT   = 15;
   localparam int PANEL_BIT = 8;
   localparam int FIDX_W    = 5;

   typedef struct packed {
      logic [7:0] a;
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
   } argb_t;

   function automatic logic [7:0] grow5(input logic [4:0] v);
      return {v, v[4:2]};
   endfunction

   function automatic logic [7:0] grow6(input logic [5:0] v);
      return {v, v[5:4]};
   endfunction

endpackage

// File: rtl/pxu_cfg_regs.sv
module pxu_cfg_regs
   import pxu_pkg::*;
#(
   parameter int CFG_W = 32,
   parameter int IDX_W = 8,
   parameter int COL_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output layout_e          layout,
   output logic             order_bgr,
   output logic             panel_swap,
   output logic             pal_we,
   output logic [IDX_W-1:0] pal_waddr,
   output logic [COL_W-1:0] pal_wdata
);

   logic [FIDX_W-1:0] fidx_q;
   logic              panel_q;
   logic [COL_W-1:0]  pdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fidx_q  <= '0;
         panel_q <= 1'b0;
         pdata_q <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            REG_FORMAT: begin
               fidx_q  <= cfg_wdata[FIDX_W-1:0];
               panel_q <= cfg_wdata[PANEL_BIT];
            end
            REG_PDATA: pdata_q <= cfg_wdata[COL_W-1:0];
            default: ;
         endcase
      end
   end

   assign layout     = layout_e'(fidx_q[FIDX_W-1:1]);
   assign order_bgr  = fidx_q[0];
   assign panel_swap = panel_q;

   // the palette write goes straight to the array on the command write
   assign pal_we    = cfg_we && (cfg_addr == REG_PCMD) && cfg_wdata[CMD_BIT];
   assign pal_waddr = cfg_wdata[IDX_W-1:0];
   assign pal_wdata = pdata_q;

   logic unused_cfg;
   assign unused_cfg = ^cfg_wdata[CFG_W-1:COL_W];

endmodule

// File: rtl/pxu_decode.sv
module pxu_decode
   import pxu_pkg::*;
#(
   parameter int PIX_W = 32,
   parameter int IDX_W = 8
) (
   input  logic [PIX_W-1:0] pix,
   input  layout_e          layout,
   output argb_t            direct,
   output logic             use_pal,
   output logic [IDX_W-1:0] pal_idx
);

   always_comb begin
      direct  = '{a: 8'hFF, r: 8'h00, g: 8'h00, b: 8'h00};
      use_pal = 1'b0;
      case (layout)
         LAY_565: begin
            direct.r = grow5(pix[15:11]);
            direct.g = grow6(pix[10:5]);
            direct.b = grow5(pix[4:0]);
         end
         LAY_1555: begin
            direct.a = {8{pix[15]}};
            direct.r = grow5(pix[14:10]);
            direct.g = grow5(pix[9:5]);
            direct.b = grow5(pix[4:0]);
         end
         LAY_PK24, LAY_UP32: begin
            direct.r = pix[23:16];
            direct.g = pix[15:8];
            direct.b = pix[7:0];
         end
         LAY_A32: begin
            direct.a = pix[31:24];
            direct.r = pix[23:16];
            direct.g = pix[15:8];
            direct.b = pix[7:0];
         end
         LAY_INDEX: use_pal = 1'b1;
         default: ;
      endcase
   end

   assign pal_idx = pix[IDX_W-1:0];

   generate
      if (PIX_W > 32) begin : g_wide
         logic unused_hi;
         assign unused_hi = ^pix[PIX_W-1:32];
      end
   endgenerate

endmodule

// File: rtl/pxu_palette.sv
module pxu_palette #(
   parameter int IDX_W   = 8,
   parameter int COL_W   = 24,
   parameter bit HAS_PAL = 1'b1
) (
   input  logic             clk,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_addr,
   output logic [COL_W-1:0] rd_data,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [COL_W-1:0] wr_data
);

   localparam int DEPTH = 1 << IDX_W;

   generate
      if (HAS_PAL) begin : g_ram
         logic [COL_W-1:0] mem [DEPTH];
         logic [COL_W-1:0] q;
         // the read samples the array before the write updates it
         always_ff @(posedge clk) begin
            if (rd_en) q <= mem[rd_addr];
            if (wr_en) mem[wr_addr] <= wr_data;
         end
         assign rd_data = q;
      end else begin : g_none
         logic unused_pal;
         assign unused_pal = ^{rd_en, rd_addr, wr_en, wr_addr, wr_data, clk};
         assign rd_data = '0;
      end
   endgenerate

endmodule

// File: rtl/pix_unpack.sv
module pix_unpack
   import pxu_pkg::*;
#(
   parameter int PIX_W   = 32,
   parameter int CFG_W   = 32,
   parameter int IDX_W   = 8,
   parameter bit HAS_PAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [PIX_W-1:0] in_pix,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [23:0]      out_rgb,
   output logic [7:0]       out_alpha
);

   localparam int COL_W = 24;

   generate
      if (PIX_W < 32) begin : g_bad_pix
         $error("pix_unpack: PIX_W must be at least 32");
      end
      if (CFG_W < 32) begin : g_bad_cfg
         $error("pix_unpack: CFG_W must be at least 32");
      end
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
         $error("pix_unpack: IDX_W must be 1 to 8");
      end
   endgenerate

   layout_e          layout;
   logic             order_bgr, panel_swap;
   logic             pal_we;
   logic [IDX_W-1:0] pal_waddr, pal_idx;
   logic [COL_W-1:0] pal_wdata, pal_q;
   argb_t            direct;
   logic             use_pal;

   pxu_cfg_regs #(.CFG_W(CFG_W), .IDX_W(IDX_W), .COL_W(COL_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .layout(layout), .order_bgr(order_bgr),
      .panel_swap(panel_swap), .pal_we(pal_we), .pal_waddr(pal_waddr),
      .pal_wdata(pal_wdata)
   );

   pxu_decode #(.PIX_W(PIX_W), .IDX_W(IDX_W)) u_dec (
      .pix(in_pix), .layout(layout), .direct(direct),
      .use_pal(use_pal), .pal_idx(pal_idx)
   );

   logic accept;
   assign accept = in_valid && in_ready;

   pxu_palette #(.IDX_W(IDX_W), .COL_W(COL_W), .HAS_PAL(HAS_PAL)) u_pal (
      .clk(clk), .rd_en(accept && use_pal), .rd_addr(pal_idx), .rd_data(pal_q),
      .wr_en(pal_we), .wr_addr(pal_waddr), .wr_data(pal_wdata)
   );

   logic  v_q, pal_q_sel, swap_q;
   argb_t col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q       <= 1'b0;
         pal_q_sel <= 1'b0;
         swap_q    <= 1'b0;
         col_q     <= '0;
      end else if (in_ready) begin
         v_q <= in_valid;
         if (in_valid) begin
            pal_q_sel <= use_pal;
            swap_q    <= order_bgr ^ panel_swap;
            col_q     <= direct;
         end
      end
   end

   assign in_ready = !v_q || out_ready;

   argb_t sel;
   always_comb begin
      sel = col_q;
      if (pal_q_sel) begin
         sel.r = pal_q[23:16];
         sel.g = pal_q[15:8];
         sel.b = pal_q[7:0];
      end
   end

   assign out_valid = v_q;
   assign out_alpha = sel.a;
   assign out_rgb   = swap_q ? {sel.b, sel.g, sel.r} : {sel.r, sel.g, sel.b};

endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        in_ready,
   input logic        out_valid,
   input logic        out_ready,
   input logic [23:0] out_rgb,
   input logic [7:0]  out_alpha
);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb) && $stable(out_alpha)));

   p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !in_valid) |=> !out_valid);

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && !in_valid) |=> !out_valid);

endmodule

bind pix_unpack pix_unpack_chk u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready),
   .out_rgb(out_rgb), .out_alpha(out_alpha)
);

// File: tb/pix_unpack_test.sv
`timescale 1ns/1ps
module pix_unpack_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_pix = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [23:0] out_rgb;
   logic [7:0]  out_alpha;

   int checks = 0;
   int errors = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [23:0] pal_m [256];
   logic [4:0]  cur_fi = '0;
   logic        cur_pan = 1'b0;
   logic        stall = 1'b0;
   logic        bp = 1'b0;
   logic [7:0]  lfsr = 8'h5A;

   always #2 clk = ~clk;

   pix_unpack uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
      .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
      .out_rgb(out_rgb), .out_alpha(out_alpha)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // expected {alpha, r, g, b} from the requirements
   function automatic logic [31:0] model(input logic [31:0] p, input logic [4:0] fi, input logic pan);
      logic [7:0] a, r, g, b, t;
      a = 8'hFF; r = 0; g = 0; b = 0;
      unique case (fi[4:1])
         4'd0: begin
            r = {p[15:11], p[15:13]}; g = {p[10:5], p[10:9]}; b = {p[4:0], p[4:2]};
         end
         4'd1: begin
            a = p[15] ? 8'hFF : 8'h00;
            r = {p[14:10], p[14:12]}; g = {p[9:5], p[9:7]}; b = {p[4:0], p[4:2]};
         end
         4'd2, 4'd3: begin r = p[23:16]; g = p[15:8]; b = p[7:0]; end
         4'd4: begin a = p[31:24]; r = p[23:16]; g = p[15:8]; b = p[7:0]; end
         4'd5: begin r = pal_m[p[7:0]][23:16]; g = pal_m[p[7:0]][15:8]; b = pal_m[p[7:0]][7:0]; end
         default: ;
      endcase
      if (fi[0] != pan) begin t = r; r = b; b = t; end
      return {a, r, g, b};
   endfunction

   always @(negedge clk) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (stall) out_ready = 1'b0;
      else if (bp) out_ready = lfsr[0];
      else out_ready = 1'b1;
   end

   // monitor: the handshake at the next edge uses the values seen here
   always begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected output", {out_alpha, out_rgb}, 32'h0);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({out_alpha, out_rgb} === e, t, {out_alpha, out_rgb}, e);
         end
      end
   end

   task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_fmt(input logic [4:0] fi, input logic pan);
      cfg_write(2'd0, {23'd0, pan, 3'd0, fi});
      cur_fi = fi; cur_pan = pan;
   endtask

   task automatic pal_write(input logic [7:0] ix, input logic [23:0] c);
      cfg_write(2'd1, {8'd0, c});
      cfg_write(2'd2, {16'd0, 8'h80, ix});
      pal_m[ix] = c;
   endtask

   task automatic send(input logic [31:0] p, input string tag);
      bit acc;
      exp_q.push_back(model(p, cur_fi, cur_pan));
      tag_q.push_back(tag);
      in_pix = p; in_valid = 1'b1;
      do begin
         #1 acc = in_ready;
         @(negedge clk);
      end while (!acc);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(negedge clk);
      check(exp_q.size() == 0, "R8 drain", exp_q.size(), 0);
   endtask

   initial begin
      #(4 * 150000);
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
      check(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // default layout after reset
      send(32'h0000FFFF, "R10 R1 default 565 white");
      send(32'h0000F800, "R1 565 red");
      send(32'h000007E0, "R1 565 green");
      send(32'h00008410, "R1 565 mid grey widening");
      drain();

      // one-cycle latency
      send(32'h0000001F, "R8 R1 565 blue");
      #1 check(out_valid == 1'b1, "R8 valid one cycle after accept", out_valid, 1);
      drain();

      set_fmt(5'd1, 1'b0);
      send(32'h0000F800, "R5 stored BGR swaps");
      set_fmt(5'd1, 1'b1);
      send(32'h0000F800, "R5 BGR with panel swap cancels");
      set_fmt(5'd0, 1'b1);
      send(32'h0000F800, "R5 panel swap alone");

      set_fmt(5'd2, 1'b0);
      send(32'h00008000, "R2 1555 alpha set black");
      send(32'h00007C00, "R2 1555 red alpha clear");
      send(32'h000003E0, "R2 1555 green");
      send(32'h0000A94A, "R2 1555 mixed");

      set_fmt(5'd4, 1'b0);
      send(32'hAB123456, "R3 packed 24 ignores top byte");
      set_fmt(5'd6, 1'b0);
      send(32'hAB123456, "R3 32-bit no alpha");
      set_fmt(5'd7, 1'b0);
      send(32'hAB123456, "R3 R5 32-bit no alpha BGR");

      set_fmt(5'd8, 1'b0);
      send(32'hAB123456, "R4 alpha passthrough");
      send(32'h00FEDCBA, "R4 zero alpha");
      set_fmt(5'd9, 1'b0);
      send(32'hAB123456, "R4 R5 alpha BGR");
      drain();

      // palette
      pal_write(8'd5, 24'h112233);
      pal_write(8'd255, 24'hA0B0C0);
      pal_write(8'd9, 24'h0F0E0D);
      set_fmt(5'd10, 1'b0);
      send(32'h00000005, "R6 palette entry 5");
      send(32'h000003FF, "R6 index uses low 8 bits");
      cfg_write(2'd1, 32'h00999999);
      cfg_write(2'd2, 32'h00000005);
      send(32'h00000005, "R6 command without write bit ignored");
      set_fmt(5'd11, 1'b0);
      send(32'h00000005, "R5 R6 indexed with swap");
      set_fmt(5'd10, 1'b0);
      drain();

      // same-cycle write and lookup of entry 9
      cfg_write(2'd1, 32'h00C1C2C3);
      repeat (2) @(negedge clk);
      exp_q.push_back(model(32'h9, cur_fi, cur_pan));
      tag_q.push_back("R7 same-cycle write returns old");
      cfg_we = 1'b1; cfg_addr = 2'd2; cfg_wdata = 32'h00008009;
      in_pix = 32'h9; in_valid = 1'b1;
      #1 check(in_ready == 1'b1, "R7 lookup accepted with write", in_ready, 1);
      @(negedge clk);
      cfg_we = 1'b0; in_valid = 1'b0;
      pal_m[9] = 24'hC1C2C3;
      send(32'h00000009, "R7 new value afterwards");
      drain();

      set_fmt(5'd12, 1'b0);
      send(32'hFFFFFFFF, "R11 undefined code black");
      set_fmt(5'd31, 1'b0);
      send(32'h12345678, "R11 top undefined code");
      drain();

      // stall hold
      stall = 1'b1;
      @(negedge clk);
      set_fmt(5'd8, 1'b0);
      send(32'h80AABBCC, "R9 stalled pixel");
      repeat (3) @(negedge clk);
      #1;
      check(out_valid == 1'b1, "R9 valid held in stall", out_valid, 1);
      check(in_ready == 1'b0, "R9 in_ready low in stall", in_ready, 0);
      check({out_alpha, out_rgb} == 32'h80AABBCC, "R9 data held in stall", {out_alpha, out_rgb}, 32'h80AABBCC);
      stall = 1'b0;
      drain();

      // ordered stream under random backpressure, mixed layouts
      bp = 1'b1;
      for (int i = 0; i < 24; i++) send(32'h01000000 * i + 32'h00030507 * i, "R8 R9 stream alpha32");
      set_fmt(5'd10, 1'b0);
      for (int i = 0; i < 12; i++) send((i % 2 == 0) ? 32'd5 : 32'd255, "R8 R9 stream indexed");
      set_fmt(5'd0, 1'b0);
      for (int i = 0; i < 16; i++) send(32'h00001111 * i, "R8 R9 stream 565");
      drain();
      bp = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule